// File: doc/BRIEF.md
# Page-Burst EEPROM Write Engine with Completion Polling

This engine sits on the host side of a byte-wide parallel EEPROM bus. A requester hands it a start address and a byte count (0 to 64) on a ready/valid command port. The bytes then arrive one at a time on a separate ready/valid stream. The engine turns them into write strobes on the memory bus. It keeps the strobes close enough together that the memory treats them as one page load.

After each burst the engine remembers the address and data of the final byte. It then reads that location back at a fixed spacing. As long as bit 7 of the returned value differs from bit 7 of the saved byte, the memory is still programming. A run that reaches a 64-byte page edge is closed there, and the rest continues as a fresh burst once polling confirms the first burst is finished. When the whole request is done, the engine returns a one-cycle done pulse. If polling runs past a cycle limit, the pulse carries an error flag and the rest of the request is dropped.

Top module: `eeprom_page_writer`

## Requirements
- R1: The command port is ready only while the engine is idle. The bytes of a request are written in arrival order to consecutive addresses, starting at the command address and wrapping modulo the address space.
- R2: Every write strobe of one burst carries the same address bits above the 6-bit in-page offset.
- R3: While the write enable output is low, chip enable is low, output enable is high and the data drive enable is high.
- R4: Within a burst, consecutive write strobes start no more than GAP_LIM + WE_LOW + WE_HIGH + 2 cycles apart. If the next byte has not arrived GAP_LIM cycles after a strobe, the burst is closed and polled, and the remaining bytes form a new burst.
- R5: Polling reads (output and chip enable low, write enable high) address only the last written location. A burst is treated as complete only when bit 7 read back equals bit 7 of the last byte written. On a mismatch the same address is read again after POLL_GAP cycles.
- R6: A run that crosses a 64-byte page boundary (the address offset goes from 63 to 0) is split into separate bursts, and each burst is polled before the next burst begins.
- R7: If one polling phase lasts TIMEOUT cycles, the engine raises done with err = 1, abandons the remaining bytes and returns to idle.
- R8: A command with a length of 0 produces done one cycle after acceptance, with no write strobe and no read.
- R9: done is high for exactly one cycle per accepted command, and err is 0 when every burst completed.
- R10: After reset the engine is idle: cmd_ready = 1, ce_n = we_n = oe_n = 1, done = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and accepting a command |
| cmd_addr | input | AW | Start address of the run |
| cmd_len | input | PAGE_BITS+1 | Byte count, 0 to 64 |
| dat_valid | input | 1 | Write byte offered |
| dat_ready | output | 1 | Engine takes the byte this cycle |
| dat_byte | input | DW | Write byte |
| mem_addr | output | AW | Memory address bus |
| mem_dout | output | DW | Data driven towards the memory |
| mem_den | output | 1 | Drive enable for mem_dout |
| mem_din | input | DW | Data returned by the memory |
| ce_n | output | 1 | Chip enable, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Polling timed out; valid with done |

## Verification
The assertions assume the requester never offers a length above 64. They also assume that mem_din is settled on the final cycle of each read, which the bench's memory model guarantees by updating its response only on the falling clock edge. The stimulus sets every command length within 0 to 64. It holds dat_valid low only where a test deliberately stalls the stream, and it sets the model's programming time so that some polls mismatch and one run exceeds TIMEOUT.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int AW        = 13,
  parameter int DW        = 8,
  parameter int PAGE_BITS = 6,
  parameter int WE_LOW    = 3,
  parameter int WE_HIGH   = 2,
  parameter int POLL_GAP  = 4,
  parameter int RD_CYC    = 2,
  parameter int GAP_LIM   = 4000,
  parameter int TIMEOUT   = 500000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [AW-1:0]        cmd_addr,
  input  logic [PAGE_BITS:0]   cmd_len,
  input  logic                 dat_valid,
  output logic                 dat_ready,
  input  logic [DW-1:0]        dat_byte,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_dout,
  output logic                 mem_den,
  input  logic [DW-1:0]        mem_din,
  output logic                 ce_n,
  output logic                 we_n,
  output logic                 oe_n,
  output logic                 done,
  output logic                 err
);

  localparam int LW = PAGE_BITS + 1;
  localparam int TW = $clog2(GAP_LIM + WE_LOW + WE_HIGH + POLL_GAP + RD_CYC + 2);
  localparam int OW = $clog2(TIMEOUT + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_STRB, S_WAIT, S_READ, S_DONE} st_t;

  st_t           st;
  logic [AW-1:0] addr, last_addr;
  logic [LW-1:0] remain;
  logic [TW-1:0] tmr;
  logic [OW-1:0] tout;
  logic [DW-1:0] wbyte;
  logic          last_b7, first, err_r;

  wire polling   = (st == S_WAIT) || (st == S_READ);
  wire page_end  = &addr[PAGE_BITS-1:0];
  wire timed_out = polling && (tout == OW'(TIMEOUT - 1));

  assign cmd_ready = (st == S_IDLE);
  assign dat_ready = (st == S_LOAD) && (tmr >= TW'(WE_HIGH));
  assign we_n      = (st != S_STRB);
  assign oe_n      = (st != S_READ);
  assign ce_n      = !((st == S_STRB) || (st == S_READ));
  assign mem_den   = (st == S_STRB);
  assign mem_dout  = wbyte;
  assign mem_addr  = polling ? last_addr : addr;
  assign done      = (st == S_DONE);
  assign err       = done & err_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      addr      <= '0;
      last_addr <= '0;
      remain    <= '0;
      tmr       <= '0;
      tout      <= '0;
      wbyte     <= '0;
      last_b7   <= 1'b0;
      first     <= 1'b1;
      err_r     <= 1'b0;
    end else begin
      if (polling) tout <= tout + 1'b1;
      unique case (st)
        S_IDLE: if (cmd_valid) begin
          addr   <= cmd_addr;
          remain <= cmd_len;
          err_r  <= 1'b0;
          first  <= 1'b1;
          tmr    <= TW'(WE_HIGH);
          st     <= (cmd_len == '0) ? S_DONE : S_LOAD;
        end
        S_LOAD: begin
          if (dat_valid && dat_ready) begin
            wbyte <= dat_byte;
            tmr   <= '0;
            st    <= S_STRB;
          end else if (!first && tmr == TW'(GAP_LIM)) begin
            tmr  <= '0;
            tout <= '0;
            st   <= S_WAIT;
          end else if (tmr < TW'(GAP_LIM)) begin
            tmr <= tmr + 1'b1;
          end
        end
        S_STRB: begin
          if (tmr == TW'(WE_LOW - 1)) begin
            last_addr <= addr;
            last_b7   <= wbyte[DW-1];
            addr      <= addr + 1'b1;
            remain    <= remain - 1'b1;
            first     <= 1'b0;
            tmr       <= '0;
            if (remain == LW'(1) || page_end) begin
              tout <= '0;
              st   <= S_WAIT;
            end else begin
              st <= S_LOAD;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_WAIT: begin
          if (timed_out) begin
            err_r <= 1'b1;
            st    <= S_DONE;
          end else if (tmr == TW'(POLL_GAP - 1)) begin
            tmr <= '0;
            st  <= S_READ;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_READ: begin
          if (timed_out) begin
            err_r <= 1'b1;
            st    <= S_DONE;
          end else if (tmr == TW'(RD_CYC - 1)) begin
            if (mem_din[DW-1] == last_b7) begin
              first <= 1'b1;
              tmr   <= TW'(WE_HIGH);
              st    <= (remain == '0) ? S_DONE : S_LOAD;
            end else begin
              tmr <= '0;
              st  <= S_WAIT;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R2
  page_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STRB && !first) |-> (addr[AW-1:PAGE_BITS] == last_addr[AW-1:PAGE_BITS]));

  // R3
  strobe_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (oe_n && !ce_n && mem_den));

  // R4
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && !first) |-> (tmr <= TW'(GAP_LIM)));

  // R5
  poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !mem_den && !ce_n));

  // R7
  timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    polling |-> (tout < OW'(TIMEOUT)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sim_eeprom_page_writer.sv
module sim_eeprom_page_writer;
  localparam int GAP_LIM = 100;
  localparam int TOUT    = 2000;
  localparam int WE_LOW  = 3;
  localparam int WE_HIGH = 2;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [12:0] cmd_addr = '0;
  logic [6:0] cmd_len = '0;
  logic dat_valid = 0, dat_ready;
  logic [7:0] dat_byte = '0;
  logic [12:0] mem_addr;
  logic [7:0] mem_dout, mem_din;
  logic mem_den, ce_n, we_n, oe_n, done, err;

  always #10 clk = ~clk;

  eeprom_page_writer #(.GAP_LIM(GAP_LIM), .TIMEOUT(TOUT), .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .dat_valid(dat_valid), .dat_ready(dat_ready),
    .dat_byte(dat_byte), .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_den(mem_den),
    .mem_din(mem_din), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .done(done), .err(err));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [7:0] mem [int];
  int exq_a[$];
  logic [7:0] exq_d[$];
  int prog_cycles = 0, busy = 0, bursts = 0, reads = 0, nwr = 0;
  int since_fall = 0, burst_page = 0;
  bit in_burst = 0, prev_we = 1, prev_oe = 1, tog = 0;
  int last_wa = 0, waddr = 0;
  logic [7:0] last_wd = '0, wdat = '0;

  initial mem_din = '0;

  // Memory model and per-clock protocol comparison
  always @(negedge clk) begin
    if (rst_n) begin
      since_fall++;
      if (!we_n) begin
        chk(oe_n && !ce_n && mem_den, "R3 strobe controls", {oe_n, ce_n, mem_den}, 3'b101);
        if (prev_we) begin
          if (in_burst)
            chk(since_fall <= GAP_LIM + WE_LOW + WE_HIGH + 2, "R4 strobe spacing", since_fall,
                GAP_LIM + WE_LOW + WE_HIGH + 2);
          since_fall = 0;
        end
        waddr = mem_addr;
        wdat  = mem_dout;
      end else if (!prev_we) begin
        if (exq_a.size() > 0) begin
          chk(waddr == exq_a[0] && wdat == exq_d[0], "R1 write order",
              {waddr, wdat}, {exq_a[0], exq_d[0]});
          void'(exq_a.pop_front());
          void'(exq_d.pop_front());
        end else chk(0, "R1 unexpected write", waddr, -1);
        if (in_burst) chk((waddr >> 6) == burst_page, "R2 page lock", waddr >> 6, burst_page);
        else burst_page = waddr >> 6;
        in_burst = 1;
        mem[waddr] = wdat;
        last_wa = waddr;
        last_wd = wdat;
        nwr++;
      end
      if (!oe_n) begin
        chk(mem_addr == last_wa && we_n, "R5 poll address", mem_addr, last_wa);
        if (prev_oe) begin
          reads++;
          tog = ~tog;
          if (in_burst) begin
            in_burst = 0;
            bursts++;
            busy = prog_cycles;
          end
        end
      end
      if (busy > 0) busy--;
      if (busy > 0) mem_din = {~last_wd[7], tog, last_wd[5:0]};
      else mem_din = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'hFF;
    end
    prev_we = we_n;
    prev_oe = oe_n;
  end

  task automatic run(input int a, input int n, input int stall_at, input int stall_len,
                     input int prog, input int exp_b, input bit exp_err, input int seed);
    logic [7:0] d[64];
    int idx, stl, cyc, acc_cyc;
    bit fin, take;
    prog_cycles = prog; bursts = 0; reads = 0; nwr = 0;
    for (int i = 0; i < n; i++) begin
      d[i] = 8'((a + i) * 37 + seed);
      exq_a.push_back((a + i) % 8192);
      exq_d.push_back(d[i]);
    end
    @(negedge clk);
    cmd_valid = 1; cmd_addr = 13'(a); cmd_len = 7'(n);
    @(negedge clk);
    cmd_valid = 0;
    chk(!cmd_ready, "R1 busy after accept", cmd_ready, 0);
    idx = 0; stl = 0; cyc = 0; fin = 0; acc_cyc = 1;
    while (!fin) begin
      if (done) begin
        fin = 1;
        dat_valid = 0;
        chk(err == exp_err, "R7/R9 err flag", err, exp_err);
        if (n == 0) begin
          chk(acc_cyc == 1 && nwr == 0 && reads == 0, "R8 empty command", acc_cyc, 1);
        end
        if (!exp_err) begin
          chk(exq_a.size() == 0 && idx == n, "R1 all bytes written", exq_a.size(), 0);
          chk(bursts == exp_b, "R6 burst count", bursts, exp_b);
          chk(busy == 0, "R5 done only after programming", busy, 0);
          if (prog >= 50) chk(reads >= 2, "R5 repeated poll", reads, 2);
        end
      end else begin
        if (cyc > 0) chk(!cmd_ready, "R1 not ready while busy", cmd_ready, 0);
        if (idx == stall_at && stl < stall_len) begin
          dat_valid = 0; stl++;
        end else if (idx < n) begin
          dat_valid = 1; dat_byte = d[idx];
        end else dat_valid = 0;
        take = dat_valid && dat_ready;
        @(negedge clk);
        if (take) idx++;
        cyc++; acc_cyc++;
        if (cyc > 30000) begin
          chk(0, "watchdog", cyc, 30000);
          fin = 1;
        end
      end
    end
    @(negedge clk);
    chk(!done && cmd_ready, "R9 single pulse, back to idle", {done, cmd_ready}, 2'b01);
    if (exp_err) begin
      busy = 0; in_burst = 0;
      exq_a.delete(); exq_d.delete();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready && ce_n && we_n && oe_n && !done, "R10 reset state",
        {cmd_ready, ce_n, we_n, oe_n, done}, 5'b11110);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && we_n && oe_n && !done, "R10 idle after reset",
        {cmd_ready, we_n, oe_n, done}, 4'b1110);
    run(13'h0010, 1, -1, 0, 30, 1, 0, 1);   // single byte
    run(13'h0040, 64, -1, 0, 80, 1, 0, 5);  // full aligned page
    run(13'h00F5, 20, -1, 0, 40, 2, 0, 9);  // R6 split across page edge
    run(13'h1FE0, 64, -1, 0, 40, 2, 0, 3);  // R6 split plus address wrap
    run(13'h0400, 8, -1, 0, 0, 1, 0, 77);   // first poll already matches
    run(13'h0100, 10, 4, GAP_LIM + 50, 30, 2, 0, 21); // R4 stalled stream
    run(13'h0200, 0, -1, 0, 30, 0, 0, 0);   // R8 zero length
    run(13'h0A00, 5, -1, 0, 100000, 1, 1, 44); // R7 timeout
    run(13'h0123, 3, -1, 0, 60, 1, 0, 12);  // recovery after timeout
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule